// File: doc/BRIEF.md
# Serial Register Port with Data-Ready Flag

This block is the host-facing slave side of a converter subsystem. A host selects it by pulling chip select low, then clocks a command byte and any following data bits through a three-wire serial link of serial clock, data in and data out. The command byte selects a read or a write and picks one of a few internal registers. Reads return bits on a data output that drives only while the port is selected. The serial pins are synchronised into the system clock and their edges are detected there, so the serial clock may run continuously or in bursts.

Conversion results arrive from the converter on a 16-bit parallel stream with a valid/ready handshake. A result is accepted on any system clock edge where both valid and ready are high. Ready falls only when the one-deep holding slot is occupied. In that case the producer must keep the same word on the bus, with valid high, until ready returns. A calibration-done strobe is a plain single-cycle control input. Both the stream and the strobe drive an active-low data-ready line. That line is released only when the host has clocked out a complete result word, so a host that reads only part of a word still sees the flag when it next looks.

Top module: `serdat_port`

## Requirements
- R1: After reset, drdy_n is 1, dout_oe is 0, dout is 0, res_ready is 1 and cfg_q equals the CFG_RST parameter (default 8'h0C).
- R2: dout_oe is 1 while cs_n is held low, after the synchroniser delay, and 0 once cs_n has been high for that delay. The data output is treated as high impedance whenever dout_oe is 0.
- R3: Each transaction starts with 8 command bits, sampled MSB first on rising SCLK edges while cs_n is low. Command bit 7 set means read and clear means write. Command bits 2:0 form the address: 1 is the configuration register, 2 is the result register and 3 is the status register. Command bits 6:3 are ignored.
- R4: In a write to address 1, the next 8 bits, MSB first, update cfg_q on the 16th rising SCLK edge. Writes to any other address leave cfg_q unchanged. SCLK and DIN activity while cs_n is high changes no state.
- R5: After a read command, dout changes only on falling SCLK edges. The first data bit appears after the falling edge that follows the 8th rising edge. The result register returns 16 bits, MSB first. The configuration and status registers return 8 bits, MSB first. Unmapped addresses return zeros.
- R6: A result accepted on the stream while no result read is under way is loaded into the result register, and drdy_n goes low.
- R7: A calibration-done pulse drives drdy_n low and leaves the result register unchanged.
- R8: drdy_n returns high only on completion of the 16th data bit of a result-register read. A read ended early by cs_n rising leaves drdy_n low.
- R9: A result accepted while a result read is under way is held in a holding slot, and res_ready stays 0 while the slot is occupied. When the read ends, whether complete or aborted, the held word moves into the result register and drdy_n goes low.
- R10: Reading the status register returns 8 bits. Bit 0 is 1 while a result or calibration event is pending, that is while drdy_n is low. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for dout (1 = drive) |
| res_data | input | 16 | Conversion result word |
| res_valid | input | 1 | Result word valid |
| res_ready | output | 1 | Port can accept a result |
| cal_done | input | 1 | One-cycle calibration finished strobe |
| drdy_n | output | 1 | Active-low data-ready flag |
| cfg_q | output | 8 | Configuration register contents |

## Verification
The hardest situation to reach is a result arriving while the host is partway through clocking out the previous one. That arrival must land in the holding slot, drop res_ready, and then reappear as a fresh data-ready indication once the read finishes. The bench reaches this state by injecting a stream handshake from inside its serial transfer task at a chosen bit index. It samples res_ready a few cycles later. It then checks that the word it reads out is the old one, that drdy_n is low again after CS rises, and that a second read returns the injected word. The same injection is repeated during an aborted read.

// File: rtl/serdat_pkg.sv
package serdat_pkg;
  localparam int CMD_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int REG_W   = 8;
  localparam int DATA_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd3;
endpackage

// File: rtl/serdat_sync.sv
module serdat_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serdat_frame.sv
module serdat_frame
  import serdat_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CMD_W,
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          sclk_s,
  input  logic          din_s,
  input  logic [DW-1:0] rd_word,
  output logic          dout,
  output logic          dout_oe,
  output logic          rd_start,
  output logic [AW-1:0] rd_addr,
  output logic          rd_done,
  output logic          xfer_end,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [RW-1:0] wr_data,
  output logic          sclk_fall,
  output logic          cs_fall
);
  localparam int RXW     = (CW > RW) ? CW : RW;
  localparam int CNT_MAX = CW + DW;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] C_CMD_END = CNT_W'(CW - 1);
  localparam logic [CNT_W-1:0] C_WR_END  = CNT_W'(CW + RW - 1);
  localparam logic [CNT_W-1:0] C_RD_END  = CNT_W'(CW + DW - 1);
  localparam logic [CNT_W-1:0] C_SAT     = CNT_W'(CNT_MAX);

  logic             sclk_d, cs_d;
  logic             sclk_rise, cs_rise;
  logic [CNT_W-1:0] cnt;
  logic [RXW-1:0]   rx;
  logic [RXW-1:0]   nb;
  logic [DW-1:0]    tx;
  logic             cmd_rd;
  logic [AW-1:0]    cmd_addr;

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  assign cs_fall   = cs_d & ~cs_n_s;
  assign cs_rise   = ~cs_d & cs_n_s;
  assign nb        = {rx[RXW-2:0], din_s};
  assign dout_oe   = ~cs_n_s;
  assign rd_addr   = cmd_addr;
  assign wr_addr   = cmd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      dout     <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      rd_start <= 1'b0;
      rd_done  <= 1'b0;
      xfer_end <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      rd_start <= 1'b0;
      rd_done  <= 1'b0;
      xfer_end <= 1'b0;
      wr_en    <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        tx     <= '0;
        dout   <= 1'b0;
        cmd_rd <= 1'b0;
      end else if (cs_rise) begin
        xfer_end <= 1'b1;
      end else begin
        if (sclk_rise) begin
          rx <= nb;
          if (cnt != C_SAT) cnt <= cnt + 1'b1;
          if (cnt == C_CMD_END) begin
            cmd_rd   <= nb[CW-1];
            cmd_addr <= nb[AW-1:0];
            rd_start <= nb[CW-1];
          end
          if (!cmd_rd && cnt == C_WR_END) begin
            wr_en   <= 1'b1;
            wr_data <= nb[RW-1:0];
          end
          if (cmd_rd && cmd_addr == ADDR_DATA && cnt == C_RD_END)
            rd_done <= 1'b1;
        end
        if (rd_start) begin
          tx <= rd_word;
        end else if (sclk_fall) begin
          dout <= tx[DW-1];
          tx   <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/serdat_ready.sv
module serdat_ready #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] res_data,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic          cal_done,
  input  logic          rd_start,
  input  logic          rd_done,
  input  logic          xfer_end,
  output logic [DW-1:0] data_q,
  output logic          drdy,
  output logic          accept,
  output logic          busy_end,
  output logic          shadow_v
);
  logic          busy_q;
  logic          eff_busy;
  logic [DW-1:0] shadow_q;

  assign res_ready = ~shadow_v;
  assign accept    = res_valid & res_ready;
  assign eff_busy  = busy_q | rd_start;
  assign busy_end  = busy_q & (rd_done | xfer_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      data_q   <= '0;
      shadow_q <= '0;
      shadow_v <= 1'b0;
      drdy     <= 1'b0;
    end else begin
      if (rd_start) busy_q <= 1'b1;
      if (busy_end) begin
        busy_q <= 1'b0;
        if (rd_done) drdy <= 1'b0;
        if (shadow_v) begin
          data_q   <= shadow_q;
          shadow_v <= 1'b0;
          drdy     <= 1'b1;
        end else if (accept) begin
          data_q <= res_data;
          drdy   <= 1'b1;
        end
      end else if (accept) begin
        if (eff_busy) begin
          shadow_q <= res_data;
          shadow_v <= 1'b1;
        end else begin
          data_q <= res_data;
          drdy   <= 1'b1;
        end
      end
      if (cal_done) drdy <= 1'b1;
    end
  end
endmodule

// File: rtl/serdat_port.sv
module serdat_port
  import serdat_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_RST     = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        din,
  output logic        dout,
  output logic        dout_oe,
  input  logic [15:0] res_data,
  input  logic        res_valid,
  output logic        res_ready,
  input  logic        cal_done,
  output logic        drdy_n,
  output logic [7:0]  cfg_q
);
  logic [2:0]        pins_s;
  logic              cs_n_s, sclk_s, din_s;
  logic [DATA_W-1:0] rd_word;
  logic              rd_start, rd_done, xfer_end, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  wr_data;
  logic              sclk_fall, cs_fall;
  logic              data_rd_start;
  logic [DATA_W-1:0] data_q;
  logic              drdy, accept, busy_end, shadow_v;
  logic [REG_W-1:0]  stat_byte;

  serdat_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(pins_s)
  );
  assign {cs_n_s, sclk_s, din_s} = pins_s;

  serdat_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
    .rd_word(rd_word), .dout(dout), .dout_oe(dout_oe), .rd_start(rd_start),
    .rd_addr(rd_addr), .rd_done(rd_done), .xfer_end(xfer_end), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sclk_fall(sclk_fall), .cs_fall(cs_fall)
  );

  assign data_rd_start = rd_start & (rd_addr == ADDR_DATA);

  serdat_ready #(.DW(DATA_W)) u_ready (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .cal_done(cal_done), .rd_start(data_rd_start),
    .rd_done(rd_done), .xfer_end(xfer_end), .data_q(data_q), .drdy(drdy),
    .accept(accept), .busy_end(busy_end), .shadow_v(shadow_v)
  );

  always_comb begin
    stat_byte    = '0;
    stat_byte[0] = drdy;
  end

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      ADDR_CFG:  rd_word[DATA_W-1 -: REG_W] = cfg_q;
      ADDR_DATA: rd_word = data_q;
      ADDR_STAT: rd_word[DATA_W-1 -: REG_W] = stat_byte;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cfg_q <= CFG_RST;
    else if (wr_en && wr_addr == ADDR_CFG) cfg_q <= wr_data;
  end

  assign drdy_n = ~drdy;
endmodule

// File: rtl/serdat_port_chk.sv
module serdat_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drdy_n,
  input logic       dout,
  input logic       res_valid,
  input logic       res_ready,
  input logic       cal_done,
  input logic       accept,
  input logic       busy_end,
  input logic       shadow_v,
  input logic       rd_done,
  input logic       sclk_fall,
  input logic       cs_fall,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] cfg_q
);
  p_release_on_full_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(rd_done));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(accept || cal_done || (busy_end && shadow_v)));

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_ready) |-> $past(res_valid));

  p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(sclk_fall || cs_fall));

  p_cfg_only_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> $past(wr_en && wr_addr == 3'd1));

  p_cal_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !drdy_n);
endmodule

bind serdat_port serdat_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .dout(dout), .res_valid(res_valid),
  .res_ready(res_ready), .cal_done(cal_done), .accept(accept), .busy_end(busy_end),
  .shadow_v(shadow_v), .rd_done(rd_done), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
  .wr_en(wr_en), .wr_addr(wr_addr), .cfg_q(cfg_q)
);

// File: tb/test_serdat_port.sv
module test_serdat_port;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic        dout, dout_oe, res_ready, drdy_n;
  logic [15:0] res_data = '0;
  logic        res_valid = 1'b0, cal_done = 1'b0;
  logic [7:0]  cfg_q;

  int          n_chk = 0, n_err = 0;
  logic [15:0] exp_q[$];
  logic [15:0] cur_exp = '0;
  logic        oe_low_seen, ready_mid;
  logic [15:0] rw;

  always #10 clk = ~clk;

  serdat_port i_serdat_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dout(dout),
    .dout_oe(dout_oe), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .cal_done(cal_done), .drdy_n(drdy_n), .cfg_q(cfg_q)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_result(input logic [15:0] v);
    @(negedge clk);
    res_data = v; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    exp_q.push_back(v);
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbits, input logic [15:0] wbits,
                      input int inj_at, input logic [15:0] inj_val,
                      output logic [15:0] rword);
    rword = '0;
    oe_low_seen = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8 + nbits; i++) begin
      din = (i < 8) ? cmd[7-i] : wbits[nbits-1-(i-8)];
      if (i == inj_at) begin
        res_data = inj_val; res_valid = 1'b1;
        @(negedge clk); res_valid = 1'b0;
        exp_q.push_back(inj_val);
        repeat (2) @(negedge clk);
        ready_mid = res_ready;
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      if (!dout_oe) oe_low_seen = 1'b1;
      if (i >= 8) rword = {rword[14:0], dout};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    din = 1'b0; cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic read_result(input string req);
    logic [15:0] w;
    xfer(8'h82, 16, 16'h0, -1, 16'h0, w);
    if (exp_q.size() > 0) cur_exp = exp_q.pop_front();
    check(req, w, cur_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 drdy_n", {15'b0, drdy_n}, 16'h1);
    check("R1 dout_oe", {15'b0, dout_oe}, 16'h0);
    check("R1 dout", {15'b0, dout}, 16'h0);
    check("R1 res_ready", {15'b0, res_ready}, 16'h1);
    check("R1 cfg_q", {8'h0, cfg_q}, 16'h000C);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R4 write config, then read back (R5)
    xfer(8'h01, 8, 16'h00A5, -1, 16'h0, rw);
    check("R4 cfg write", {8'h0, cfg_q}, 16'h00A5);
    check("R2 oe while selected", {15'b0, oe_low_seen}, 16'h0);
    check("R2 oe after deselect", {15'b0, dout_oe}, 16'h0);
    xfer(8'hF9, 8, 16'h0, -1, 16'h0, rw);  // bits 6:3 ignored, address 1 (R3)
    check("R5 cfg read", rw, 16'h00A5);
    // R4 write to other address ignored
    xfer(8'h02, 8, 16'h0033, -1, 16'h0, rw);
    check("R4 write elsewhere", {8'h0, cfg_q}, 16'h00A5);
    // R4 activity with cs high ignored
    for (int k = 0; k < 16; k++) begin
      din = k[0]; sclk = ~sclk; repeat (HALF) @(negedge clk);
    end
    sclk = 1'b0; din = 1'b0;
    check("R4 cs high cfg", {8'h0, cfg_q}, 16'h00A5);
    check("R4 cs high drdy", {15'b0, drdy_n}, 16'h1);
    // R5 unmapped read
    xfer(8'h86, 8, 16'h0, -1, 16'h0, rw);
    check("R5 unmapped", rw, 16'h0);
    // R10 status idle
    xfer(8'h83, 8, 16'h0, -1, 16'h0, rw);
    check("R10 status idle", rw, 16'h0000);

    // R6 result loads and flags
    push_result(16'h1234);
    repeat (2) @(negedge clk);
    check("R6 drdy low", {15'b0, drdy_n}, 16'h0);
    xfer(8'h83, 8, 16'h0, -1, 16'h0, rw);
    check("R10 status pending", rw, 16'h0001);
    // R8 aborted read keeps flag
    xfer(8'h82, 10, 16'h0, -1, 16'h0, rw);
    check("R8 abort partial bits", rw, 16'h0048);
    check("R8 abort keeps flag", {15'b0, drdy_n}, 16'h0);
    read_result("R5 R6 result word");
    check("R8 full read releases", {15'b0, drdy_n}, 16'h1);

    // R7 calibration done
    @(negedge clk); cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
    @(negedge clk);
    check("R7 cal flag", {15'b0, drdy_n}, 16'h0);
    read_result("R7 data unchanged");
    check("R7 release after read", {15'b0, drdy_n}, 16'h1);

    // R9 result arriving during a read
    push_result(16'h5A5A);
    xfer(8'h82, 16, 16'h0, 12, 16'hBEEF, rw);
    cur_exp = exp_q.pop_front();
    check("R9 old word read", rw, cur_exp);
    check("R9 ready low while held", {15'b0, ready_mid}, 16'h0);
    check("R9 flag after read", {15'b0, drdy_n}, 16'h0);
    check("R9 ready restored", {15'b0, res_ready}, 16'h1);
    read_result("R9 held word");
    check("R9 released", {15'b0, drdy_n}, 16'h1);

    // R9 during an aborted read
    xfer(8'h82, 6, 16'h0, 10, 16'hC0DE, rw);
    check("R9 abort ready low", {15'b0, ready_mid}, 16'h0);
    check("R9 abort flag", {15'b0, drdy_n}, 16'h0);
    read_result("R9 abort held word");
    check("R8 final release", {15'b0, drdy_n}, 16'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule